// File: doc/BRIEF.md
# Real-Time-Clock Register Bank

This block is the register side of a serial-bus real-time clock. A bus front end, not part of this block, turns bus traffic into three kinds of one-cycle strobe: a START condition, a received byte, and a request for the next byte to transmit. Behind these strobes the block keeps a 64-byte register space. Bytes 0 to 6 hold the calendar time in BCD. Byte 7 is a control byte that is only stored. Bytes 8 to 63 are general-purpose storage. A free-running calendar counter advances once per pulse of a one-second tick input.

The byte that a read returns never comes from the running counter. Each START copies the running time into a frozen set of shadow bytes, so a multi-byte read always sees one consistent instant. The copy is taken again whenever the auto-incrementing pointer rolls over from the top of the space back to byte 0. A write to a time byte loads only that field of the running counter, and every other field keeps counting. The hours byte can be written and read in 24-hour form or in 12-hour form with an AM/PM flag.

Top module: `rtc_regbank`

## Requirements
- R1: After reset, the pointer is 0, bytes 7 to 63 read 0x00, and the time bytes 0 to 6 read 00, 00, 00, 01, 01, 01, 00 (seconds, minutes, hours in 24-hour form, weekday, date, month, year).
- R2: The first byte received after a START loads the pointer with its low 6 bits and ignores bits 7:6. That byte writes no register.
- R3: The pointer steps by one after every data byte received and after every byte read, and steps from 63 to 0.
- R4: A data byte received at pointer 7 to 63 is stored there and is read back unchanged.
- R5: A START copies the running time into shadow bytes 0 to 6 as BCD. Reads of bytes 0 to 6 return the shadow, so ticks that come after the START do not change what is read.
- R6: When the pointer steps from 63 to 0, the running time is copied into the shadow again, and the next read of byte 0 shows the time at that step.
- R7: Each tick advances the seconds. The carry passes from seconds (59 to 0) into minutes (59 to 0), from minutes into hours (23 to 0), and from hours into the next day.
- R8: On a day carry, the weekday goes from 7 back to 1. The date passes the month's last day: 30 for months 4, 6, 9 and 11, 31 for the other months, and for month 2 it is 29 when the year is divisible by 4 and 28 otherwise. Month 12 rolls to 1 and carries into the year, and year 99 rolls to 00.
- R9: The hours byte (byte 2) uses bit 6 as the 12-hour mode flag. With bit 6 set, bit 5 is PM and bits 4:0 hold a BCD hour from 1 to 12. With bit 6 clear, bits 5:0 hold a BCD hour from 0 to 23.
- R10: Writing the hours byte in 12-hour form sets the running hour as follows: 12 AM becomes hour 0, 12 PM becomes hour 12, and any other PM hour h becomes h+12. The running hour is then shown in the mode that was written.
- R11: Writes to the time bytes ignore these bits: bit 7 of the seconds and minutes bytes, bits 7:3 of the weekday byte, bits 7:6 of the date byte and bits 7:5 of the month byte.
- R12: A write to one time byte changes only that field. The other fields keep their values and keep counting on later ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sec_tick | input | 1 | One-cycle pulse, once per second |
| bus_start | input | 1 | START condition seen on the bus |
| bus_wr | input | 1 | Strobe: a received byte is valid on bus_wdata |
| bus_wdata | input | 8 | Received byte |
| bus_rd | input | 1 | Strobe: bus_rdata has been taken; move to the next byte |
| bus_rdata | output | 8 | Byte at the current pointer |

## Verification
The hardest case to reach from the ports is a shadow refresh caused by pointer rollover in the middle of a read. The bench gets there by pointing at byte 62 and issuing a START, so the shadow holds an old second. It lets the clock tick, then reads through bytes 62 and 63 and expects byte 0 to show the newer second. The calendar rollovers are only reached after long runs of ticks. To reach them, the bench writes a time one second before each month end, in both a leap and a non-leap year, in both hour forms and across year 99, and then gives a single tick.

// File: rtl/rtc_pkg.sv
`timescale 1ns/1ps
package rtc_pkg;

    localparam int TIME_REGS = 7;
    localparam int FIELD_W   = $clog2(TIME_REGS);

    typedef enum logic [2:0] {
        FLD_SEC  = 3'd0,
        FLD_MIN  = 3'd1,
        FLD_HOUR = 3'd2,
        FLD_DOW  = 3'd3,
        FLD_DATE = 3'd4,
        FLD_MON  = 3'd5,
        FLD_YEAR = 3'd6,
        FLD_CTRL = 3'd7
    } field_e;

    // Running time, binary fields, hour always in 0..23
    typedef struct packed {
        logic       h12;
        logic [6:0] year;
        logic [6:0] mon;
        logic [6:0] date;
        logic [6:0] dow;
        logic [6:0] hour;
        logic [6:0] min;
        logic [6:0] sec;
    } rtc_time_t;

    localparam rtc_time_t TIME_AT_RESET = '{h12: 1'b0, year: 7'd0, mon: 7'd1,
                                            date: 7'd1, dow: 7'd1, hour: 7'd0,
                                            min: 7'd0, sec: 7'd0};

    function automatic logic [7:0] to_bcd(input logic [6:0] v);
        logic [7:0] w;
        w = {1'b0, v};
        return ((w / 8'd10) << 4) | (w % 8'd10);
    endfunction

    function automatic logic [6:0] from_bcd(input logic [7:0] b);
        return {3'b0, b[7:4]} * 7'd10 + {3'b0, b[3:0]};
    endfunction

    function automatic logic [6:0] month_days(input logic [6:0] mon, input logic [6:0] year);
        case (mon)
            7'd2:                      return (year[1:0] == 2'b00) ? 7'd29 : 7'd28;
            7'd4, 7'd6, 7'd9, 7'd11:   return 7'd30;
            default:                   return 7'd31;
        endcase
    endfunction

    function automatic rtc_time_t step_time(input rtc_time_t t);
        rtc_time_t n;
        n = t;
        if (t.sec >= 7'd59) begin
            n.sec = 7'd0;
            if (t.min >= 7'd59) begin
                n.min = 7'd0;
                if (t.hour >= 7'd23) begin
                    n.hour = 7'd0;
                    n.dow  = (t.dow >= 7'd7) ? 7'd1 : t.dow + 7'd1;
                    if (t.date >= month_days(t.mon, t.year)) begin
                        n.date = 7'd1;
                        if (t.mon >= 7'd12) begin
                            n.mon  = 7'd1;
                            n.year = (t.year >= 7'd99) ? 7'd0 : t.year + 7'd1;
                        end else begin
                            n.mon = t.mon + 7'd1;
                        end
                    end else begin
                        n.date = t.date + 7'd1;
                    end
                end else begin
                    n.hour = t.hour + 7'd1;
                end
            end else begin
                n.min = t.min + 7'd1;
            end
        end else begin
            n.sec = t.sec + 7'd1;
        end
        return n;
    endfunction

    function automatic logic [7:0] hour_byte(input logic [6:0] hour, input logic h12);
        logic [6:0] v;
        if (!h12) return to_bcd(hour);
        v = (hour >= 7'd12) ? hour - 7'd12 : hour;
        if (v == 7'd0) v = 7'd12;
        return 8'h40 | ((hour >= 7'd12) ? 8'h20 : 8'h00) | to_bcd(v);
    endfunction

    function automatic logic [6:0] hour_from_byte(input logic [7:0] d);
        logic [6:0] h;
        if (d[6]) begin
            h = from_bcd({3'b0, d[4:0]});
            if (h == 7'd12) return d[5] ? 7'd12 : 7'd0;
            return d[5] ? h + 7'd12 : h;
        end
        return from_bcd({2'b0, d[5:0]});
    endfunction

    function automatic logic [7:0] field_byte(input logic [2:0] idx, input rtc_time_t t);
        case (field_e'(idx))
            FLD_SEC:  return to_bcd(t.sec);
            FLD_MIN:  return to_bcd(t.min);
            FLD_HOUR: return hour_byte(t.hour, t.h12);
            FLD_DOW:  return to_bcd(t.dow);
            FLD_DATE: return to_bcd(t.date);
            FLD_MON:  return to_bcd(t.mon);
            FLD_YEAR: return to_bcd(t.year);
            default:  return 8'h00;
        endcase
    endfunction

    function automatic rtc_time_t apply_write(input rtc_time_t t, input logic [2:0] idx,
                                              input logic [7:0] d);
        rtc_time_t n;
        n = t;
        case (field_e'(idx))
            FLD_SEC:  n.sec  = from_bcd({1'b0, d[6:0]});
            FLD_MIN:  n.min  = from_bcd({1'b0, d[6:0]});
            FLD_HOUR: begin
                n.hour = hour_from_byte(d);
                n.h12  = d[6];
            end
            FLD_DOW:  n.dow  = {4'b0, d[2:0]};
            FLD_DATE: n.date = from_bcd({2'b0, d[5:0]});
            FLD_MON:  n.mon  = from_bcd({3'b0, d[4:0]});
            FLD_YEAR: n.year = from_bcd(d);
            default:  ;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/rtc_live_clock.sv
`timescale 1ns/1ps
module rtc_live_clock
    import rtc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                tick,
    input  logic                wr_en,
    input  logic [FIELD_W-1:0]  wr_field,
    input  logic [7:0]          wr_byte,
    output rtc_time_t           now
);
    rtc_time_t stepped;
    rtc_time_t nxt;

    // A tick in the same cycle is applied first; the written field then overrides
    always_comb begin
        stepped = tick  ? step_time(now) : now;
        nxt     = wr_en ? apply_write(stepped, wr_field, wr_byte) : stepped;
    end

    always_ff @(posedge clk) begin
        if (rst) now <= TIME_AT_RESET;
        else     now <= nxt;
    end
endmodule

// File: rtl/rtc_snapshot.sv
`timescale 1ns/1ps
module rtc_snapshot
    import rtc_pkg::*;
#(
    parameter int N = TIME_REGS
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  capture,
    input  rtc_time_t             now,
    output logic [N-1:0][7:0]     snap
);
    for (genvar i = 0; i < N; i++) begin : g_shadow
        logic [7:0] q;
        always_ff @(posedge clk) begin
            if (rst)          q <= field_byte(3'(i), TIME_AT_RESET);
            else if (capture) q <= field_byte(3'(i), now);
        end
        assign snap[i] = q;
    end
endmodule

// File: rtl/rtc_pointer.sv
`timescale 1ns/1ps
module rtc_pointer #(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              wr,
    input  logic              rd,
    input  logic [ADDR_W-1:0] load_val,
    output logic [ADDR_W-1:0] ptr,
    output logic              addr_phase,
    output logic              data_wr,
    output logic              wrap
);
    logic data_rd;
    logic step;

    assign data_wr = wr && !addr_phase && !start;
    assign data_rd = rd && !start;
    assign step    = data_wr || data_rd;
    assign wrap    = step && (ptr == '1);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr        <= '0;
            addr_phase <= 1'b0;
        end else if (start) begin
            addr_phase <= 1'b1;
        end else if (wr && addr_phase) begin
            ptr        <= load_val;
            addr_phase <= 1'b0;
        end else if (step) begin
            ptr <= ptr + 1'b1;
        end
    end
endmodule

// File: rtl/rtc_regbank.sv
`timescale 1ns/1ps
module rtc_regbank
    import rtc_pkg::*;
#(
    parameter int NUM_BYTES = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sec_tick,
    input  logic       bus_start,
    input  logic       bus_wr,
    input  logic [7:0] bus_wdata,
    input  logic       bus_rd,
    output logic [7:0] bus_rdata
);
    localparam int ADDR_W = $clog2(NUM_BYTES);
    localparam int RAM_N  = NUM_BYTES - TIME_REGS;

    logic [ADDR_W-1:0]        ptr;
    logic                     addr_phase;
    logic                     data_wr;
    logic                     wrap;
    logic                     is_time;
    logic [ADDR_W-1:0]        ram_idx;
    rtc_time_t                live;
    logic [TIME_REGS-1:0][7:0] snap;
    logic [7:0]               ram [RAM_N];

    assign is_time = ptr < ADDR_W'(TIME_REGS);
    assign ram_idx = ptr - ADDR_W'(TIME_REGS);

    rtc_pointer #(.ADDR_W(ADDR_W)) u_ptr (
        .clk        (clk),
        .rst        (rst),
        .start      (bus_start),
        .wr         (bus_wr),
        .rd         (bus_rd),
        .load_val   (bus_wdata[ADDR_W-1:0]),
        .ptr        (ptr),
        .addr_phase (addr_phase),
        .data_wr    (data_wr),
        .wrap       (wrap)
    );

    rtc_live_clock u_clock (
        .clk      (clk),
        .rst      (rst),
        .tick     (sec_tick),
        .wr_en    (data_wr && is_time),
        .wr_field (ptr[FIELD_W-1:0]),
        .wr_byte  (bus_wdata),
        .now      (live)
    );

    rtc_snapshot #(.N(TIME_REGS)) u_snap (
        .clk     (clk),
        .rst     (rst),
        .capture (bus_start || wrap),
        .now     (live),
        .snap    (snap)
    );

    // Control byte and user storage share one array
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < RAM_N; i++) ram[i] <= 8'h00;
        end else if (data_wr && !is_time) begin
            ram[ram_idx] <= bus_wdata;
        end
    end

    always_comb begin
        if (is_time) bus_rdata = snap[ptr[FIELD_W-1:0]];
        else         bus_rdata = ram[ram_idx];
    end
endmodule

// File: rtl/rtc_regbank_chk.sv
`timescale 1ns/1ps
module rtc_regbank_chk
    import rtc_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      sec_tick,
    input logic                      bus_start,
    input logic                      bus_wr,
    input logic                      bus_rd,
    input logic [ADDR_W-1:0]         load_val,
    input logic [ADDR_W-1:0]         ptr,
    input logic                      addr_phase,
    input logic                      wrap,
    input logic [6:0]                sec,
    input logic [6:0]                min,
    input logic [6:0]                hour,
    input logic [TIME_REGS-1:0][7:0] snap
);
    // R1
    reset_ptr_chk: assert property (@(posedge clk) rst |=> (ptr == '0));

    // R2
    addr_load_chk: assert property (@(posedge clk) disable iff (rst)
        (addr_phase && bus_wr && !bus_start) |=> (ptr == $past(load_val)));

    // R3
    ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (((bus_wr && !addr_phase) || bus_rd) && !bus_start)
        |=> (ptr == ADDR_W'($past(ptr) + 1'b1)));

    // R5
    snap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!bus_start && !wrap) |=> $stable(snap));

    // R6
    wrap_zero_chk: assert property (@(posedge clk) disable iff (rst)
        wrap |=> (ptr == '0));

    // R7
    sec_count_chk: assert property (@(posedge clk) disable iff (rst)
        (sec_tick && !bus_wr && sec < 7'd59) |=> (sec == $past(sec) + 7'd1));

    // R7
    time_range_chk: assert property (@(posedge clk) disable iff (rst)
        (sec < 7'd60) && (min < 7'd60) && (hour < 7'd24));
endmodule

bind rtc_regbank rtc_regbank_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .sec_tick   (sec_tick),
    .bus_start  (bus_start),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .load_val   (bus_wdata[ADDR_W-1:0]),
    .ptr        (ptr),
    .addr_phase (addr_phase),
    .wrap       (wrap),
    .sec        (live.sec),
    .min        (live.min),
    .hour       (live.hour),
    .snap       (snap)
);

// File: tb/rtc_regbank_test.sv
`timescale 1ns/1ps
module rtc_regbank_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sec_tick = 1'b0;
    logic       bus_start = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;

    int checks = 0;
    int fails  = 0;

    rtc_regbank uut (
        .clk(clk), .rst(rst), .sec_tick(sec_tick), .bus_start(bus_start),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] bcd(input int v);
        return 8'(((v / 10) * 16) + (v % 10));
    endfunction

    function automatic logic [7:0] h12byte(input int h);
        int v;
        v = h % 12;
        if (v == 0) v = 12;
        return 8'h40 | ((h >= 12) ? 8'h20 : 8'h00) | bcd(v);
    endfunction

    function automatic int dim(input int m, input int y);
        if (m == 2) return (y % 4 == 0) ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    function automatic logic [7:0] pat(input int i);
        return 8'(i * 37 + 5);
    endfunction

    task automatic strobe_start();
        @(negedge clk); bus_start = 1'b1;
        @(negedge clk); bus_start = 1'b0;
    endtask

    task automatic put(input logic [7:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic get(output logic [7:0] d);
        @(negedge clk); d = bus_rdata; bus_rd = 1'b1;
        @(negedge clk); bus_rd = 1'b0;
    endtask

    task automatic tick(input int n);
        @(negedge clk); sec_tick = 1'b1;
        repeat (n) @(negedge clk);
        sec_tick = 1'b0;
    endtask

    task automatic load_addr(input logic [7:0] a);
        strobe_start();
        put(a);
    endtask

    task automatic set_time(input logic [7:0] s, mi, h, dw, dt, mo, yr);
        load_addr(8'h00);
        put(s); put(mi); put(h); put(dw); put(dt); put(mo); put(yr);
    endtask

    task automatic get_time(output logic [7:0] t [7]);
        load_addr(8'h00);
        strobe_start();
        for (int i = 0; i < 7; i++) get(t[i]);
    endtask

    task automatic chk_time(input string req, input logic [7:0] t [7],
                            input logic [7:0] s, mi, h, dw, dt, mo, yr);
        chk({req, " sec"},   t[0], s);
        chk({req, " min"},   t[1], mi);
        chk({req, " hour"},  t[2], h);
        chk({req, " dow"},   t[3], dw);
        chk({req, " date"},  t[4], dt);
        chk({req, " month"}, t[5], mo);
        chk({req, " year"},  t[6], yr);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic [7:0] t [7];
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset contents over the whole space
        chk("R1 rdata at reset", bus_rdata, 8'h00);
        strobe_start();
        for (int i = 0; i < 64; i++) begin
            get(d);
            chk("R1 reset byte", d, (i >= 3 && i <= 5) ? 8'h01 : 8'h00);
        end

        // R4 / R3: fill 7..63 in one burst, read back, wrap to byte 0
        load_addr(8'd7);
        for (int i = 7; i < 64; i++) put(pat(i));
        load_addr(8'd7);
        strobe_start();
        for (int i = 7; i < 64; i++) begin
            get(d);
            chk("R4 storage readback", d, pat(i));
        end
        get(d);
        chk("R3 pointer wrap to byte 0", d, 8'h00);
        get(d);
        chk("R3 step after wrap", d, 8'h00);

        // R2: address byte upper bits ignored
        strobe_start();
        put(8'hC0 | 8'd20);
        put(8'h5A);
        load_addr(8'd20);
        strobe_start();
        get(d);
        chk("R2 masked pointer load", d, 8'h5A);
        get(d);
        chk("R2 neighbour untouched", d, pat(21));

        // R9: 24-hour sweep
        for (int h = 0; h < 24; h++) begin
            load_addr(8'd2);
            put(bcd(h));
            get_time(t);
            chk("R9 24h hour", t[2], bcd(h));
        end
        // R9 / R10: 12-hour sweep round trip
        for (int h = 0; h < 24; h++) begin
            load_addr(8'd2);
            put(h12byte(h));
            get_time(t);
            chk("R10 12h hour", t[2], h12byte(h));
        end

        // R7: carry seconds->minutes->hours
        set_time(8'h59, 8'h59, 8'h09, 8'h03, 8'h15, 8'h06, 8'h21);
        tick(1);
        get_time(t);
        chk_time("R7 hour carry", t, 8'h00, 8'h00, 8'h10, 8'h03, 8'h15, 8'h06, 8'h21);
        set_time(8'h58, 8'h07, 8'h09, 8'h03, 8'h15, 8'h06, 8'h21);
        tick(3);
        get_time(t);
        chk("R7 minute carry sec", t[0], 8'h01);
        chk("R7 minute carry min", t[1], 8'h08);

        // R8: month ends in a non-leap and a leap year
        for (int yi = 0; yi < 2; yi++) begin
            for (int m = 1; m <= 12; m++) begin
                int y;
                y = (yi == 0) ? 21 : 24;
                set_time(8'h59, 8'h59, 8'h23, 8'h07, bcd(dim(m, y)), bcd(m), bcd(y));
                tick(1);
                get_time(t);
                chk_time("R8 month end", t, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01,
                         bcd((m == 12) ? 1 : m + 1), bcd((m == 12) ? y + 1 : y));
            end
        end
        set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h24);
        tick(1);
        get_time(t);
        chk("R8 leap Feb 29 date", t[4], 8'h29);
        chk("R8 leap Feb 29 month", t[5], 8'h02);

        // R10 / R8: 11:59:59 PM Dec 31 year 99 -> 12 AM Jan 1 year 00
        set_time(8'h59, 8'h59, 8'h71, 8'h07, 8'h31, 8'h12, 8'h99);
        tick(1);
        get_time(t);
        chk_time("R10 midnight rollover", t, 8'h00, 8'h00, 8'h52, 8'h01, 8'h01, 8'h01, 8'h00);
        // R10: 11:59:59 AM -> 12 PM
        set_time(8'h59, 8'h59, 8'h51, 8'h04, 8'h10, 8'h05, 8'h30);
        tick(1);
        get_time(t);
        chk("R10 noon", t[2], 8'h72);
        chk("R10 noon date kept", t[4], 8'h10);

        // R11: write masks
        set_time(8'hB5, 8'hC7, 8'h14, 8'hF3, 8'hD5, 8'hE9, 8'h42);
        get_time(t);
        chk_time("R11 masks", t, 8'h35, 8'h47, 8'h14, 8'h03, 8'h15, 8'h09, 8'h42);

        // R12: single-field write, others keep counting
        set_time(8'h30, 8'h20, 8'h10, 8'h02, 8'h11, 8'h04, 8'h25);
        load_addr(8'd1);
        put(8'h45);
        tick(2);
        get_time(t);
        chk_time("R12 single field", t, 8'h32, 8'h45, 8'h10, 8'h02, 8'h11, 8'h04, 8'h25);

        // R5: snapshot frozen after START
        load_addr(8'd0);
        put(8'h10);
        load_addr(8'd0);
        strobe_start();
        tick(3);
        get(d);
        chk("R5 frozen seconds", d, 8'h10);

        // R6: rollover refreshes the snapshot (live now 13)
        load_addr(8'd62);
        strobe_start();
        tick(2);
        get(d);
        chk("R6 byte 62", d, pat(62));
        get(d);
        chk("R6 byte 63", d, pat(63));
        get(d);
        chk("R6 refreshed seconds", d, 8'h15);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule